// File: doc/BRIEF.md
# Time-Resolved Multichannel Event Counter

The block builds a time-of-arrival histogram of detector pulses. After an arming command, a rising edge on the trigger input starts a sweep. The sweep steps through a programmed number of consecutive time bins, each a programmed whole number of clock cycles wide. Every rising edge seen on the pulse input during the sweep adds one to the count of the bin that is current at that moment. Both inputs are asynchronous, active-high logic levels. Each passes through a two-stage synchroniser before its edges are detected.

One arming covers a programmed number of sweeps. After each sweep the block waits for the next trigger edge and adds that sweep's counts to the counts already stored. This lets many repetitions of an experiment sum into one histogram. The active output is high exactly while a sweep is counting, and the armed output stays high until the last programmed sweep has ended.

A single-cycle clear command empties the histogram. A host reads bins back through a registered address/data port, which returns data only while no sweep is counting. At the intended 80 MHz clock, a pulse must be high for at least one clock period to be seen. Edges arrive at most one every two cycles, which gives a 40 MHz ceiling on the count rate.

Top module: `tof_hist_counter`

## Requirements
- R1: After reset, active and armed are low, rd_data is 0 and every bin reads 0.
- R2: When armed and idle, a rising edge on trig_in sampled before clock edge s makes active go high after edge s+2. Active then stays high for exactly bins*width cycles, after which the sweep ends.
- R3: A rising edge on pulse_in sampled before edge e adds one to bin floor(j/width), where j = e-s-1 and 0 <= j < bins*width. A level held high counts once. Edges outside the sweep are not counted.
- R4: A trig_in rising edge is ignored while the block is not armed or while a sweep is counting.
- R5: One arming runs the latched number of sweeps. Counts add across sweeps, and armed falls when the last sweep ends.
- R6: Configuration is latched at arming. A bin count of 0 means 1, and a bin count above NBINS_MAX means NBINS_MAX. A width of 0 means 1, and a sweep count of 0 means 1.
- R7: A bin count stops at 2^CNT_W-1 and never wraps.
- R8: clear empties all bins in one cycle when armed is low. While armed, clear is ignored.
- R9: rd_data shows the count of bin rd_addr one clock after the address is presented. It reads 0 in any cycle that follows a cycle in which active was high.
- R10: arm is ignored while armed is high, so the running sweep count and configuration are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (80 MHz intended) |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Asynchronous start trigger, rising edge |
| pulse_in | input | 1 | Asynchronous detector pulse, rising edge |
| arm | input | 1 | Latch configuration and arm for a run of sweeps |
| clear | input | 1 | Empty all bins (idle only) |
| cfg_bins | input | AW+1 | Number of bins per sweep |
| cfg_width | input | BW_W | Bin width in clock cycles |
| cfg_sweeps | input | SW_W | Sweeps per arming |
| rd_addr | input | AW | Bin to read |
| rd_data | output | CNT_W | Count of the bin read, one cycle later |
| active | output | 1 | High while a sweep is counting |
| armed | output | 1 | High while sweeps remain |

## Verification
A wrong bin index or tick counter shows up at the ports as a sweep length off by whole cycles, which the bench sees within one sweep. It also shows up as counts shifted into a neighbouring bin, seen at the next readout. A broken sweep counter or arming latch shows on the armed output as soon as a sweep ends. A lost clear, a lost saturation or a wrapped count appears on the next bin read. The bench compares every bin against its own model after each scenario, so a corrupted cell is found before another sweep can mask it.

// File: rtl/tofh_pkg.sv
package tofh_pkg;

  // Map a requested count onto 1..hi (R6)
  function automatic int unsigned fit_range(int unsigned req, int unsigned hi);
    if (req == 0) return 1;
    if (req > hi) return hi;
    return req;
  endfunction

  // Saturating increment (R7)
  function automatic longint unsigned sat_next(longint unsigned v, longint unsigned top);
    return (v >= top) ? top : v + 1;
  endfunction

  // Largest value held in a w-bit cell
  function automatic longint unsigned cell_top(int unsigned w);
    return (64'd1 << w) - 64'd1;
  endfunction

endpackage

// File: rtl/tofh_edge_sync.sv
module tofh_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  // chain[STAGES-1] is the last synchroniser stage, chain[STAGES] its delayed copy
  assign rise = chain[STAGES-1] & ~chain[STAGES];

  // R3: a detected edge cannot repeat in the next cycle (one event per two cycles)
  a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tofh_sequencer.sv
module tofh_sequencer
  import tofh_pkg::*;
#(
  parameter int NBINS_MAX = 1024,
  parameter int AW        = 10,
  parameter int BW_W      = 16,
  parameter int SW_W      = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic [AW:0]     cfg_bins,
  input  logic [BW_W-1:0] cfg_width,
  input  logic [SW_W-1:0] cfg_sweeps,
  input  logic            start_rise,
  input  logic            pulse_rise,
  output logic            active,
  output logic            armed,
  output logic            hit,
  output logic [AW-1:0]   hit_bin
);
  logic [AW:0]     nb_lat;
  logic [BW_W-1:0] bw_lat;
  logic [SW_W-1:0] left;
  logic [BW_W-1:0] tick;
  logic [AW-1:0]   bin;
  logic            active_q, armed_q;

  // named internal events
  logic arm_ok, start_ok, bin_done, sweep_end, last_sweep;

  assign arm_ok     = arm & ~armed_q;
  assign start_ok   = armed_q & ~active_q & start_rise;
  assign bin_done   = active_q && (tick == bw_lat - BW_W'(1));
  assign sweep_end  = bin_done && ({1'b0, bin} == nb_lat - (AW+1)'(1));
  assign last_sweep = (left == SW_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      active_q <= 1'b0;
      nb_lat   <= (AW+1)'(1);
      bw_lat   <= BW_W'(1);
      left     <= '0;
      tick     <= '0;
      bin      <= '0;
    end else begin
      if (arm_ok) begin
        armed_q <= 1'b1;
        nb_lat  <= (AW+1)'(fit_range(int'(cfg_bins), NBINS_MAX));
        bw_lat  <= BW_W'(fit_range(int'(cfg_width), (1 << BW_W) - 1));
        left    <= SW_W'(fit_range(int'(cfg_sweeps), (1 << SW_W) - 1));
      end
      if (start_ok) begin
        active_q <= 1'b1;
        tick     <= '0;
        bin      <= '0;
      end else if (active_q) begin
        if (bin_done) begin
          tick <= '0;
          if (sweep_end) begin
            active_q <= 1'b0;
            left     <= left - SW_W'(1);
            if (last_sweep) armed_q <= 1'b0;
          end else begin
            bin <= bin + AW'(1);
          end
        end else begin
          tick <= tick + BW_W'(1);
        end
      end
    end
  end

  assign active  = active_q;
  assign armed   = armed_q;
  assign hit     = active_q & pulse_rise;
  assign hit_bin = bin;

  // R2: a sweep keeps counting until its final tick
  a_r2_stay_active: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !sweep_end) |=> active_q);
  // R5: end of sweep drops active
  a_r5_end_drops: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_end |=> !active_q);
  // R4: counting never happens outside an armed run
  a_r4_active_armed: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> armed_q);
  // R6: bin index stays below the latched bin count
  a_r6_bin_range: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> ({1'b0, bin} < nb_lat));
  // R10: latched run settings do not move while armed except at sweep end
  a_r10_arm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !sweep_end) |=> ($stable(left) && $stable(nb_lat) && $stable(bw_lat)));
endmodule

// File: rtl/tofh_hist_mem.sv
module tofh_hist_mem
  import tofh_pkg::*;
#(
  parameter int AW    = 10,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             active,
  input  logic             clear,
  input  logic             hit,
  input  logic [AW-1:0]    hit_bin,
  input  logic [AW-1:0]    rd_addr,
  output logic [CNT_W-1:0] rd_data
);
  localparam int NSLOT = 1 << AW;
  localparam logic [CNT_W-1:0] TOPV = CNT_W'(cell_top(CNT_W));

  logic [CNT_W-1:0] cells [NSLOT];
  logic [NSLOT-1:0] live;
  logic [CNT_W-1:0] cur_val, nxt_val, rd_val;
  logic             clear_ok;

  assign clear_ok = clear & ~armed;
  assign cur_val  = live[hit_bin] ? cells[hit_bin] : '0;
  assign nxt_val  = CNT_W'(sat_next(64'(cur_val), 64'(TOPV)));
  assign rd_val   = live[rd_addr] ? cells[rd_addr] : '0;

  always_ff @(posedge clk) begin
    if (hit) cells[hit_bin] <= nxt_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        live <= '0;
    else if (clear_ok) live <= '0;
    else if (hit)      live[hit_bin] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= '0;
    else if (active) rd_data <= '0;
    else             rd_data <= rd_val;
  end

  // R7: a full cell stays full
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && live[hit_bin] && cells[hit_bin] == TOPV) |=> (cells[$past(hit_bin)] == TOPV));
  // R9: no data leaves the port while counting
  a_r9_quiet_read: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (rd_data == '0));
  // R8: clear while armed leaves contents alone
  a_r8_clear_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && armed && !hit) |=> $stable(live));
endmodule

// File: rtl/tof_hist_counter.sv
module tof_hist_counter #(
  parameter int NBINS_MAX = 1024,
  parameter int CNT_W     = 32,
  parameter int BW_W      = 16,
  parameter int SW_W      = 16,
  parameter int SYNC_ST   = 2,
  localparam int AW       = $clog2(NBINS_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             pulse_in,
  input  logic             arm,
  input  logic             clear,
  input  logic [AW:0]      cfg_bins,
  input  logic [BW_W-1:0]  cfg_width,
  input  logic [SW_W-1:0]  cfg_sweeps,
  input  logic [AW-1:0]    rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             active,
  output logic             armed
);
  logic start_rise, pulse_rise, hit;
  logic [AW-1:0] hit_bin;

  tofh_edge_sync #(.STAGES(SYNC_ST)) u_trig (
    .clk(clk), .rst_n(rst_n), .async_in(trig_in), .rise(start_rise));

  tofh_edge_sync #(.STAGES(SYNC_ST)) u_pulse (
    .clk(clk), .rst_n(rst_n), .async_in(pulse_in), .rise(pulse_rise));

  tofh_sequencer #(.NBINS_MAX(NBINS_MAX), .AW(AW), .BW_W(BW_W), .SW_W(SW_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_bins(cfg_bins), .cfg_width(cfg_width),
    .cfg_sweeps(cfg_sweeps), .start_rise(start_rise), .pulse_rise(pulse_rise),
    .active(active), .armed(armed), .hit(hit), .hit_bin(hit_bin));

  tofh_hist_mem #(.AW(AW), .CNT_W(CNT_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .armed(armed), .active(active), .clear(clear),
    .hit(hit), .hit_bin(hit_bin), .rd_addr(rd_addr), .rd_data(rd_data));

  // R1: nothing counts before an arming has happened
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !active);
endmodule

// File: tb/sim_tof_hist_counter.sv
module sim_tof_hist_counter;
  localparam int MAXB  = 64;
  localparam int CW    = 8;
  localparam int TOP   = (1 << CW) - 1;
  localparam int AW    = 6;

  logic clk = 0, rst_n = 0;
  logic trig_in = 0, pulse_in = 0, arm = 0, clear = 0;
  logic [AW:0] cfg_bins = 0;
  logic [15:0] cfg_width = 0, cfg_sweeps = 0;
  logic [AW-1:0] rd_addr = 0;
  logic [CW-1:0] rd_data;
  logic active, armed;

  int errors = 0, checks = 0;
  int expm [MAXB];
  bit m_armed = 0;
  int m_left = 0, m_nb = 1, m_bw = 1;
  bit done = 0;

  always #2.5 clk = ~clk;

  tof_hist_counter #(.NBINS_MAX(MAXB), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .pulse_in(pulse_in), .arm(arm),
    .clear(clear), .cfg_bins(cfg_bins), .cfg_width(cfg_width), .cfg_sweeps(cfg_sweeps),
    .rd_addr(rd_addr), .rd_data(rd_data), .active(active), .armed(armed));

  function automatic int clampv(int v, int hi);
    return (v == 0) ? 1 : ((v > hi) ? hi : v);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic read_all(string req);
    for (int a = 0; a < MAXB; a++) begin
      rd_addr = AW'(a);
      @(negedge clk);
      check(rd_data == CW'(expm[a]), req, $sformatf("bin %0d", a), rd_data, expm[a]);
    end
  endtask

  task automatic do_arm(int nb, int bw, int sw);
    cfg_bins = (AW+1)'(nb); cfg_width = 16'(bw); cfg_sweeps = 16'(sw);
    arm = 1;
    @(negedge clk);
    arm = 0;
    if (!m_armed) begin  // R10: model ignores arm while armed
      m_armed = 1;
      m_nb = clampv(nb, MAXB); m_bw = clampv(bw, 65535); m_left = clampv(sw, 65535);
    end
    @(negedge clk);
  endtask

  task automatic do_clear();
    clear = 1;
    @(negedge clk);
    clear = 0;
    if (!m_armed) for (int a = 0; a < MAXB; a++) expm[a] = 0;
    @(negedge clk);
  endtask

  // pmode 0: random pulses, 1: alternating, 2: one held level
  task automatic run_sweep(bit rnd_trig, int pmode);
    int nw = m_nb * m_bw;
    bit prev = 0, p;
    int act_bad = 0, rd_bad = 0;
    rd_addr = 0;
    for (int k = 0; k < nw + 6; k++) begin
      if (active != ((k >= 3) && (k <= nw + 2))) act_bad++;
      if (k >= 4 && k <= nw + 2 && rd_data != 0) rd_bad++;
      trig_in = (k < 2) || (rnd_trig && k >= 4 && k <= nw - 2 && ($urandom % 2 == 1));
      case (pmode)
        0: p = !prev && ($urandom % 3 == 0);
        1: p = !prev;
        default: p = (k >= 1 && k <= nw);
      endcase
      if (k >= nw + 3) p = 0;
      pulse_in = p;
      if (p && !prev && k >= 1 && k <= nw) begin
        int b = (k - 1) / m_bw;
        expm[b] = (expm[b] >= TOP) ? TOP : expm[b] + 1;   // R7 model
      end
      prev = p;
      @(negedge clk);
    end
    trig_in = 0; pulse_in = 0;
    check(act_bad == 0, "R2", "active window mismatches", act_bad, 0);
    check(rd_bad == 0, "R9", "nonzero reads during sweep", rd_bad, 0);
    m_left--;
    if (m_left == 0) m_armed = 0;
    check(armed == m_armed, "R5", "armed after sweep", armed, m_armed);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int a = 0; a < MAXB; a++) expm[a] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(active == 0, "R1", "active", active, 0);
    check(armed == 0, "R1", "armed", armed, 0);
    check(rd_data == 0, "R1", "rd_data", rd_data, 0);
    read_all("R1");

    // R4: trigger without arming
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
        trig_in = k[1]; pulse_in = k[0];
        @(negedge clk);
        if (active) seen++;
      end
      trig_in = 0; pulse_in = 0;
      repeat (4) @(negedge clk);
      check(seen == 0 && active == 0, "R4", "active without arm", seen, 0);
      read_all("R4");
    end

    // R3 directed: alternating pulses, 8 bins of 3
    do_arm(8, 3, 1);
    run_sweep(1, 1);
    read_all("R3");

    // R3 held level counts once
    do_arm(4, 2, 1);
    run_sweep(0, 2);
    read_all("R3");

    // R5 / R10 / R8: three sweeps, re-arm and clear ignored while armed
    do_arm(6, 2, 3);
    do_arm(2, 1, 1);
    do_clear();
    for (int s = 0; s < 3; s++) run_sweep(1, 0);
    check(armed == 0, "R10", "armed after latched sweeps", armed, 0);
    read_all("R8");

    // R8 clear while idle
    do_clear();
    read_all("R8");

    // R6 clamping of zero and oversize settings
    do_arm(0, 0, 0);
    run_sweep(0, 1);
    read_all("R6");
    do_arm(100, 1, 1);
    run_sweep(1, 0);
    read_all("R6");

    // R7 saturation
    do_clear();
    do_arm(1, 40, 14);
    for (int s = 0; s < 14; s++) run_sweep(1, 1);
    check(expm[0] == TOP, "R7", "model saturated", expm[0], TOP);
    read_all("R7");

    // random mixes
    for (int r = 0; r < 5; r++) begin
      int nb = 1 + $urandom % MAXB;
      int bw = 1 + $urandom % 4;
      int sw = 1 + $urandom % 3;
      do_arm(nb, bw, sw);
      for (int s = 0; s < sw; s++) run_sweep(nb * bw >= 8, 0);
      read_all("R3");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule